// File: doc/BRIEF.md
# Masked-Match Content Addressable Memory

This block is a content addressable memory of 64 words. It can be used as an ordinary memory: a word is written at a 6-bit address, and a read returns that word one cycle later. Every word carries a valid flag. A write sets the flag. A separate invalidate port clears it, and reset clears every flag. The stored data bits stay in place when a flag is cleared.

Its main use is the masked search. A search key and a bit mask are presented to all words in the same cycle. Each valid word is compared with the key only on the bit positions where the mask holds a 1. Every word that agrees raises its own hit line. A priority encoder then turns the hit lines into the binary address of the highest matching word, together with a flag that tells whether any word agreed. Typical uses are lookup of partial network addresses and tag search, where the mask selects the bits that matter.

The search result is registered. It appears one cycle after the search command, with a result strobe.

Top module: `masked_cam`

## Requirements
- R1: After reset every valid flag is clear. `rd_ack`, `srch_ack` and `srch_hit` are low, and a search with an all-zero mask reports no hit until a word has been written.
- R2: A write with `wr_en` stores `wr_data` at `wr_addr` and sets that word's flag. A read with `rd_en` returns the word and its flag on `rd_data` / `rd_flag`, with `rd_ack` high, one cycle later.
- R3: An invalidate with `inv_en` clears the flag of the word at `inv_addr` and leaves its data bits unchanged. A later read returns the old bits with `rd_flag` at 0.
- R4: A search compares the key only where `srch_mask` is 1, so bits where the mask is 0 never prevent a hit. An all-zero mask hits every valid word.
- R5: A word whose flag is clear never hits, whatever its contents.
- R6: When several words hit, `srch_addr` carries the highest of their addresses as an unsigned binary number, with bit 0 as the least significant bit.
- R7: `srch_ack` is high exactly one cycle after a cycle with `srch_en`. `srch_hit` is high only together with `srch_ack`, and only when at least one word hit. When there is no hit, `srch_addr` is 0.
- R8: A search issued in the same cycle as a write works on the contents from before that write.
- R9: When a write and an invalidate address the same word in the same cycle, the data is stored and the flag ends up clear.
- R10: Words 0 to 5 hold 0x674243A4, 0x6725643E, 0x68425786, 0x12D64368, 0xE4B64802 and 0x75367843. With these words the following results hold:
  - key 0x89424858, mask 0x00FF0000, flags 5:0 = 000101: hit at 2.
  - key 0x05943864, mask 0x0000F000, flags 000000: no hit.
  - key 0x674243A4, mask 0xFFFFFFFF, flags 000001: hit at 0.
  - mask 0, flags 111111: hit at 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 32 | Write data |
| inv_en | input | 1 | Invalidate strobe |
| inv_addr | input | 6 | Invalidate address |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 6 | Read address |
| rd_ack | output | 1 | Read result strobe |
| rd_data | output | 32 | Read data |
| rd_flag | output | 1 | Valid flag of the word that was read |
| srch_en | input | 1 | Search strobe |
| srch_key | input | 32 | Search key |
| srch_mask | input | 32 | Significant-bit mask, 1 = compare |
| srch_ack | output | 1 | Search result strobe |
| srch_hit | output | 1 | At least one valid word hit |
| srch_addr | output | 6 | Highest hitting address |

## Verification
If a valid flag is set or cleared by mistake, a search with an all-zero mask shows it on the next cycle: `srch_addr` names the wrong highest word, or `srch_hit` takes the wrong value. Writing a unique word at each address and searching for each one, with a full mask and with a low-byte mask, ties every address bit of the encoder and every compare lane to one result per address. A mistake in the comparator or in the encoder therefore shows up one cycle after the search that touches it. Stepping the highest valid word down one address at a time covers every group boundary of the encoder tree.

// File: rtl/cam_pkg.sv
package cam_pkg;
   // Implementation style of the highest-index encoder
   typedef enum logic {
      ENC_LINEAR = 1'b0,
      ENC_TREE   = 1'b1
   } cam_enc_e;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [AW-1:0]               wr_addr,
   input  logic [WIDTH-1:0]            wr_data,
   input  logic                        inv_en,
   input  logic [AW-1:0]               inv_addr,
   output logic [DEPTH-1:0][WIDTH-1:0] words,
   output logic [DEPTH-1:0]            flags
);
   always_ff @(posedge clk) begin
      if (wr_en) words[wr_addr] <= wr_data;
   end

   // invalidate is applied after write, so it wins on a shared address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         if (wr_en)  flags[wr_addr]  <= 1'b1;
         if (inv_en) flags[inv_addr] <= 1'b0;
      end
   end
endmodule

// File: rtl/cam_match_lines.sv
module cam_match_lines #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 32
) (
   input  logic [DEPTH-1:0][WIDTH-1:0] words,
   input  logic [DEPTH-1:0]            flags,
   input  logic [WIDTH-1:0]            key,
   input  logic [WIDTH-1:0]            mask,
   output logic [DEPTH-1:0]            lines
);
   for (genvar r = 0; r < DEPTH; r++) begin : g_row
      assign lines[r] = flags[r] & ~|((words[r] ^ key) & mask);
   end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc
   import cam_pkg::*;
#(
   parameter int       N     = 64,
   parameter cam_enc_e STYLE = ENC_TREE,
   parameter int       GROUP = 8,
   localparam int      AW    = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [AW-1:0] idx
);
   if (STYLE == ENC_LINEAR) begin : g_linear
      always_comb begin
         any = |req;
         idx = '0;
         for (int i = 0; i < N; i++) begin
            if (req[i]) idx = AW'(i);
         end
      end
   end else begin : g_tree
      localparam int NG  = N / GROUP;
      localparam int GW  = $clog2(GROUP);
      localparam int GAW = $clog2(NG);

      if (NG < 2 || N % GROUP != 0 || (GROUP & (GROUP - 1)) != 0 || GROUP < 2) begin : g_bad
         $error("cam_prio_enc: GROUP must be a power of two dividing N at least twice");
      end

      function automatic logic [GW-1:0] top_in_group(input logic [GROUP-1:0] v);
         logic [GW-1:0] t;
         t = '0;
         for (int i = 0; i < GROUP; i++) begin
            if (v[i]) t = GW'(i);
         end
         return t;
      endfunction

      logic [NG-1:0]         grp_any;
      logic [NG-1:0][GW-1:0] grp_idx;

      for (genvar g = 0; g < NG; g++) begin : g_grp
         assign grp_any[g] = |req[g*GROUP +: GROUP];
         assign grp_idx[g] = top_in_group(req[g*GROUP +: GROUP]);
      end

      always_comb begin
         any = |grp_any;
         idx = '0;
         for (int g = 0; g < NG; g++) begin
            if (grp_any[g]) idx = {GAW'(g), grp_idx[g]};
         end
      end
   end
endmodule

// File: rtl/masked_cam.sv
module masked_cam
   import cam_pkg::*;
#(
   parameter int       DEPTH     = 64,
   parameter int       WIDTH     = 32,
   parameter cam_enc_e ENC_STYLE = ENC_TREE,
   parameter int       ENC_GROUP = 8,
   localparam int      AW        = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             inv_en,
   input  logic [AW-1:0]    inv_addr,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic             rd_ack,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_flag,
   input  logic             srch_en,
   input  logic [WIDTH-1:0] srch_key,
   input  logic [WIDTH-1:0] srch_mask,
   output logic             srch_ack,
   output logic             srch_hit,
   output logic [AW-1:0]    srch_addr
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("masked_cam: DEPTH must be a power of two, at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("masked_cam: WIDTH must be positive");
   end

   logic [DEPTH-1:0][WIDTH-1:0] words;
   logic [DEPTH-1:0]            flags;
   logic [DEPTH-1:0]            lines;
   logic                        enc_any;
   logic [AW-1:0]               enc_idx;

   cam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .inv_en  (inv_en),
      .inv_addr(inv_addr),
      .words   (words),
      .flags   (flags)
   );

   cam_match_lines #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_lines (
      .words(words),
      .flags(flags),
      .key  (srch_key),
      .mask (srch_mask),
      .lines(lines)
   );

   cam_prio_enc #(.N(DEPTH), .STYLE(ENC_STYLE), .GROUP(ENC_GROUP)) u_enc (
      .req(lines),
      .any(enc_any),
      .idx(enc_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ack    <= 1'b0;
         rd_data   <= '0;
         rd_flag   <= 1'b0;
         srch_ack  <= 1'b0;
         srch_hit  <= 1'b0;
         srch_addr <= '0;
      end else begin
         rd_ack   <= rd_en;
         srch_ack <= srch_en;
         if (rd_en) begin
            rd_data <= words[rd_addr];
            rd_flag <= flags[rd_addr];
         end
         srch_hit  <= srch_en & enc_any;
         srch_addr <= (srch_en && enc_any) ? enc_idx : '0;
      end
   end
endmodule

// File: rtl/masked_cam_chk.sv
module masked_cam_chk #(
   parameter int  DEPTH = 64,
   parameter int  WIDTH = 32,
   localparam int AW    = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          rd_en,
   input logic          rd_ack,
   input logic          srch_en,
   input logic          srch_ack,
   input logic          srch_hit,
   input logic [AW-1:0] srch_addr
);
   logic seen_wr;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     seen_wr <= 1'b0;
      else if (wr_en) seen_wr <= 1'b1;
   end

   AST_SRCH_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n) srch_en |=> srch_ack)  // R7
      else $error("search strobe not acknowledged");
   AST_SRCH_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) !srch_en |=> !srch_ack)  // R7
      else $error("spurious search acknowledge");
   AST_HIT_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n) srch_hit |-> srch_ack)  // R7
      else $error("hit without acknowledge");
   AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (srch_ack && !srch_hit) |-> (srch_addr == '0))  // R7
      else $error("address not zero on miss");
   AST_RD_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_ack)  // R2
      else $error("read not acknowledged");
   AST_NO_HIT_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (srch_ack && !seen_wr) |-> !srch_hit)  // R1
      else $error("hit with no word ever written");
endmodule

bind masked_cam masked_cam_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .rd_ack   (rd_ack),
   .srch_en  (srch_en),
   .srch_ack (srch_ack),
   .srch_hit (srch_hit),
   .srch_addr(srch_addr)
);

// File: tb/masked_cam_bench.sv
`timescale 1ns/1ps
module masked_cam_bench;
   localparam int DEPTH = 64;
   localparam int WIDTH = 32;
   localparam int AW    = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0, inv_en = 1'b0, rd_en = 1'b0, srch_en = 1'b0;
   logic [AW-1:0]    wr_addr = '0, inv_addr = '0, rd_addr = '0;
   logic [WIDTH-1:0] wr_data = '0, srch_key = '0, srch_mask = '0;
   logic             rd_ack, rd_flag, srch_ack, srch_hit;
   logic [WIDTH-1:0] rd_data;
   logic [AW-1:0]    srch_addr;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   masked_cam #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_masked_cam (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .inv_en(inv_en), .inv_addr(inv_addr),
      .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data), .rd_flag(rd_flag),
      .srch_en(srch_en), .srch_key(srch_key), .srch_mask(srch_mask),
      .srch_ack(srch_ack), .srch_hit(srch_hit), .srch_addr(srch_addr)
   );

   function automatic logic [WIDTH-1:0] pat(input int i);
      return 32'hA5000000 ^ (32'(i) * 32'h01010101);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [WIDTH-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic inv(input int a);
      @(negedge clk);
      inv_en = 1'b1; inv_addr = AW'(a);
      @(negedge clk);
      inv_en = 1'b0;
   endtask

   task automatic rd_chk(input int a, input logic [WIDTH-1:0] ed, input bit ef, input string req);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      chk(rd_ack == 1'b1, req, 32'(rd_ack), 32'd1);
      chk(rd_data == ed, req, rd_data, ed);
      chk(rd_flag == ef, req, 32'(rd_flag), 32'(ef));
   endtask

   task automatic srch_chk(input logic [WIDTH-1:0] k, input logic [WIDTH-1:0] m,
                           input bit eh, input int ea, input string req);
      @(negedge clk);
      srch_en = 1'b1; srch_key = k; srch_mask = m;
      @(negedge clk);
      srch_en = 1'b0;
      chk(srch_ack == 1'b1, req, 32'(srch_ack), 32'd1);
      chk(srch_hit == eh, req, 32'(srch_hit), 32'(eh));
      chk(srch_addr == (eh ? AW'(ea) : '0), req, 32'(srch_addr), eh ? 32'(ea) : 32'd0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(!rd_ack && !srch_ack && !srch_hit, "R1 reset outputs", {rd_ack, srch_ack, srch_hit}, 0);
      srch_chk('0, '0, 1'b0, 0, "R1 empty search");

      // R2: fill every word with a unique pattern
      for (int i = 0; i < DEPTH; i++) wr(i, pat(i));
      rd_chk(37, pat(37), 1'b1, "R2 read back");

      // R6 exact search per address; R4 low-byte mask ignores the rest
      for (int i = 0; i < DEPTH; i++) begin
         srch_chk(pat(i), '1, 1'b1, i, "R6 exact per row");
         srch_chk({~pat(i)[31:8], pat(i)[7:0]}, 32'h000000FF, 1'b1, i, "R4 masked bits");
      end
      srch_chk(32'h12345678, '0, 1'b1, 63, "R4 R6 zero mask highest");

      // R5: step the highest valid word down
      for (int k = DEPTH - 1; k >= 1; k--) begin
         inv(k);
         srch_chk('0, '0, 1'b1, k - 1, "R5 invalid rows skipped");
      end
      inv(0);
      srch_chk('0, '0, 1'b0, 0, "R7 no valid word");
      srch_chk(pat(9), '1, 1'b0, 0, "R5 invalid exact data");
      rd_chk(5, pat(5), 1'b0, "R3 invalidate keeps data");

      // R8: write and search in one cycle see old contents
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'd10; wr_data = 32'h0BADF00D;
      srch_en = 1'b1; srch_key = 32'h0BADF00D; srch_mask = '1;
      @(negedge clk);
      wr_en = 1'b0; srch_en = 1'b0;
      chk(srch_ack && !srch_hit, "R8 search before write", {srch_ack, srch_hit}, 32'd2);
      srch_chk(32'h0BADF00D, '1, 1'b1, 10, "R8 search after write");
      rd_chk(10, 32'h0BADF00D, 1'b1, "R2 read written word");

      // R9: write and invalidate on one address
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'd20; wr_data = 32'h13572468;
      inv_en = 1'b1; inv_addr = 6'd20;
      @(negedge clk);
      wr_en = 1'b0; inv_en = 1'b0;
      rd_chk(20, 32'h13572468, 1'b0, "R9 invalidate wins");
      srch_chk(32'h13572468, '1, 1'b0, 0, "R9 no hit");

      // R1: reset clears flags
      do_reset();
      srch_chk('0, '0, 1'b0, 0, "R1 reset clears flags");

      // R10: worked vectors
      wr(0, 32'h674243A4); wr(1, 32'h6725643E); wr(2, 32'h68425786);
      wr(3, 32'h12D64368); wr(4, 32'hE4B64802); wr(5, 32'h75367843);
      inv(1); inv(3); inv(4); inv(5);
      srch_chk(32'h89424858, 32'h00FF0000, 1'b1, 2, "R10 vector A");
      inv(0); inv(2);
      srch_chk(32'h05943864, 32'h0000F000, 1'b0, 0, "R10 vector B");
      wr(0, 32'h674243A4);
      srch_chk(32'h674243A4, 32'hFFFFFFFF, 1'b1, 0, "R10 vector C");
      wr(1, 32'h6725643E); wr(2, 32'h68425786); wr(3, 32'h12D64368);
      wr(4, 32'hE4B64802); wr(5, 32'h75367843);
      srch_chk(32'h3859AB34, 32'h00000000, 1'b1, 5, "R10 vector D");

      @(negedge clk);
      chk(!srch_ack && !rd_ack, "R7 strobes idle", {srch_ack, rd_ack}, 0);
      summary();
      $finish;
   end
endmodule